// File: doc/BRIEF.md
# Code-Point Priority Table with Indirect Host Access

The block maps the 6-bit differentiated-services code point, taken from the traffic-class byte of a received IP packet, to a 3-bit frame priority. It holds 64 entries, one for each code point. The switch datapath presents a code point on a lookup port and gets the stored priority back one clock later.

Software cannot address the entries directly. It uses four 32-bit registers on a simple register bus: a command register, a write-data register, a read-data register and a status register. Each write to the command register starts one table access. The command gives a direction bit and an entry index. The access takes a fixed number of cycles, and software polls a pending flag in the status register until the access is done. The storage has a single port that the lookup path shares. When both want the port, the lookup wins and the host access waits.

Top module: `dscp_prio_table`

## Requirements
- R1: After reset every entry holds priority 0, and the command, write-data, read-data and status registers all read 0.
- R2: A command-register write with bit 7 = 0 copies write-data bits 2:0 into the entry selected by command bits 5:0. Register word addresses are 0 for command, 1 for write data, 2 for read data and 3 for status.
- R3: A command-register write with bit 7 = 1 loads the selected entry into read-data bits 2:0 once the access finishes. Read-data bits 31:3 read 0.
- R4: The pending flag is status bit 0. It rises in the cycle after a command is accepted. With no lookups in progress, it stays set for exactly ACCESS_CYCLES cycles (default 3).
- R5: A lookup presented with its valid strobe in one cycle drives that entry's priority, and a result-valid strobe, in the next cycle.
- R6: While the lookup strobe is high, a pending access cannot complete. Each lookup cycle that arrives when the access would otherwise finish adds one cycle to the pending time.
- R7: A command-register write while pending is set is ignored. The command readback, the pending flag and all table entries are left unchanged by it.
- R8: Command-register bits 31:8 and bit 6 always read 0. Bit 7 reads back the direction and bits 5:0 read back the index. Write-data bits 31:3 read 0.
- R9: Status bits 31:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| lkValid | input | 1 | Lookup request strobe |
| lkCode | input | 6 | Code point to look up |
| lkPrio | output | 3 | Priority returned for the previous request |
| lkPrioValid | output | 1 | High in the cycle after a lookup request |

## Verification
The assertions assume that register writes and lookup requests are single-cycle strobes sampled at the rising edge, and that the bus address is free of unknowns whenever a strobe is high. They also assume that a lookup strobe may stay high for any number of cycles, since an access only stalls and never fails. The stimulus changes every input at the falling edge and returns the strobes low before the next rising edge, unless a scenario deliberately holds the lookup strobe high to stall an access. No input is ever left unknown after reset.

// File: rtl/dscp_prio_pkg.sv
package dscp_prio_pkg;
  localparam int IDX_W       = 6;
  localparam int PRIO_W      = 3;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 2;
  localparam int ENTRIES     = 1 << IDX_W;
  localparam int CMD_DIR_BIT = 7;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_WDAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RDAT = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic              tblWe;
    logic              tblRe;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] wdat;
  } tblStrobe_t;
endpackage

// File: rtl/dscp_prio_ctrl.sv
module dscp_prio_ctrl
  import dscp_prio_pkg::*;
#(
  parameter int ACCESS_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              lkValid,
  input  logic [PRIO_W-1:0] wrDataQ,
  output tblStrobe_t        strobe,
  output logic              cmdDir,
  output logic [IDX_W-1:0]  cmdIdx,
  output logic              pending
);
  localparam int CNT_W = $clog2(ACCESS_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0]  stepCnt;
  logic [PRIO_W-1:0] snapData;
  logic              cmdHit;
  logic              launch;
  logic              lastStep;
  logic              finish;

  always_comb begin
    cmdHit   = busWe && (busAddr == ADDR_CMD);
    launch   = cmdHit && !pending;
    lastStep = pending && (stepCnt == CNT_ONE);
    finish   = lastStep && !lkValid;   // lookups own the port
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdDir   <= 1'b0;
      cmdIdx   <= '0;
      snapData <= '0;
      pending  <= 1'b0;
      stepCnt  <= '0;
    end else if (launch) begin
      cmdDir   <= busWdata[CMD_DIR_BIT];
      cmdIdx   <= busWdata[IDX_W-1:0];
      snapData <= wrDataQ;
      pending  <= 1'b1;
      stepCnt  <= CNT_LOAD;
    end else if (pending) begin
      if (stepCnt > CNT_ONE) begin
        stepCnt <= stepCnt - CNT_ONE;
      end else if (finish) begin
        pending <= 1'b0;
        stepCnt <= '0;
      end
    end
  end

  always_comb begin
    strobe.tblWe = finish && !cmdDir;
    strobe.tblRe = finish && cmdDir;
    strobe.idx   = cmdIdx;
    strobe.wdat  = snapData;
  end
endmodule

// File: rtl/dscp_prio_data.sv
module dscp_prio_data
  import dscp_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  tblStrobe_t        strobe,
  input  logic              cmdDir,
  input  logic [IDX_W-1:0]  cmdIdx,
  input  logic              pending,
  input  logic              lkValid,
  input  logic [IDX_W-1:0]  lkCode,
  output logic [PRIO_W-1:0] lkPrio,
  output logic              lkPrioValid,
  output logic [PRIO_W-1:0] wrDataQ
);
  logic [PRIO_W-1:0] entry [ENTRIES];
  logic [PRIO_W-1:0] rdDataQ;

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[g] <= '0;
      end else if (strobe.tblWe && (strobe.idx == IDX_W'(g))) begin
        entry[g] <= strobe.wdat;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkPrio      <= '0;
      lkPrioValid <= 1'b0;
      rdDataQ     <= '0;
      wrDataQ     <= '0;
    end else begin
      lkPrioValid <= lkValid;
      if (lkValid) lkPrio <= entry[lkCode];
      if (strobe.tblRe) rdDataQ <= entry[strobe.idx];
      if (busWe && (busAddr == ADDR_WDAT)) wrDataQ <= busWdata[PRIO_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_CMD: begin
        busRdata[CMD_DIR_BIT] = cmdDir;
        busRdata[IDX_W-1:0]   = cmdIdx;
      end
      ADDR_WDAT: busRdata[PRIO_W-1:0] = wrDataQ;
      ADDR_RDAT: busRdata[PRIO_W-1:0] = rdDataQ;
      ADDR_STAT: busRdata[0]          = pending;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/dscp_prio_table.sv
module dscp_prio_table
  import dscp_prio_pkg::*;
#(
  parameter int ACCESS_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              lkValid,
  input  logic [IDX_W-1:0]  lkCode,
  output logic [PRIO_W-1:0] lkPrio,
  output logic              lkPrioValid
);
  tblStrobe_t        strobe;
  logic              cmdDir;
  logic [IDX_W-1:0]  cmdIdx;
  logic              pending;
  logic [PRIO_W-1:0] wrDataQ;

  dscp_prio_ctrl #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (regWe),
    .busAddr  (regAddr),
    .busWdata (regWdata),
    .lkValid  (lkValid),
    .wrDataQ  (wrDataQ),
    .strobe   (strobe),
    .cmdDir   (cmdDir),
    .cmdIdx   (cmdIdx),
    .pending  (pending)
  );

  dscp_prio_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .busWe       (regWe),
    .busAddr     (regAddr),
    .busWdata    (regWdata),
    .busRdata    (regRdata),
    .strobe      (strobe),
    .cmdDir      (cmdDir),
    .cmdIdx      (cmdIdx),
    .pending     (pending),
    .lkValid     (lkValid),
    .lkCode      (lkCode),
    .lkPrio      (lkPrio),
    .lkPrioValid (lkPrioValid),
    .wrDataQ     (wrDataQ)
  );
endmodule

// File: rtl/dscp_prio_table_chk.sv
module dscp_prio_table_chk
  import dscp_prio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regRdata,
  input logic              lkValid,
  input logic              lkPrioValid,
  input logic              pending,
  input logic              cmdDir,
  input logic [IDX_W-1:0]  cmdIdx
);
  localparam int RSV_LO = CMD_DIR_BIT + 1;

  assert_launch_sets_pending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CMD && !pending) |=> pending);

  assert_busy_cmd_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CMD && pending && !lkValid) |=>
      ($stable(cmdDir) && $stable(cmdIdx)));

  assert_lookup_blocks_finish_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pending && lkValid) |=> pending);

  assert_lookup_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> lkPrioValid);

  assert_no_spurious_result_R5: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !lkPrioValid);

  assert_cmd_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CMD) |-> (regRdata[REG_W-1:RSV_LO] == '0 && regRdata[IDX_W] == 1'b0));

  assert_status_upper_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STAT) |-> (regRdata[REG_W-1:1] == '0));
endmodule

bind dscp_prio_table dscp_prio_table_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWe       (regWe),
  .regAddr     (regAddr),
  .regRdata    (regRdata),
  .lkValid     (lkValid),
  .lkPrioValid (lkPrioValid),
  .pending     (pending),
  .cmdDir      (cmdDir),
  .cmdIdx      (cmdIdx)
);

// File: tb/tb_dscp_prio_table.sv
`timescale 1ns/1ps
module tb_dscp_prio_table;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [1:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic        lkValid;
  logic [5:0]  lkCode;
  logic [2:0]  lkPrio;
  logic        lkPrioValid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  dscp_prio_table dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lkValid(lkValid),
    .lkCode(lkCode), .lkPrio(lkPrio), .lkPrioValid(lkPrioValid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(output int cyc);
    logic [31:0] s;
    cyc = 0;
    regRead(2'd3, s);
    while (s[0] && cyc < 50) begin
      cyc++;
      @(negedge clk);
      regRead(2'd3, s);
    end
  endtask

  task automatic lookup(input logic [5:0] code, output logic [2:0] p, output logic v);
    lkValid = 1'b1; lkCode = code;
    @(negedge clk);
    lkValid = 1'b0;
    p = lkPrio; v = lkPrioValid;
  endtask

  task automatic writeEntry(input logic [5:0] idx, input logic [2:0] val);
    int c;
    regWrite(2'd1, {29'd0, val});
    regWrite(2'd0, {24'd0, 2'b00, idx});
    waitIdle(c);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [2:0] p; logic v;
    regRead(2'd0, d); chk("R1 cmd", d, 0);
    regRead(2'd1, d); chk("R1 wdata", d, 0);
    regRead(2'd2, d); chk("R1 rdata", d, 0);
    regRead(2'd3, d); chk("R1 status", d, 0);
    lookup(6'd0, p, v);  chk("R1 entry0", {29'd0, p}, 0);
    lookup(6'd63, p, v); chk("R1 entry63", {29'd0, p}, 0);
  endtask

  task automatic t_latency;
    int c; logic [31:0] d;
    regWrite(2'd1, 32'd3);
    regWrite(2'd0, 32'h0000_0014);
    regRead(2'd3, d); chk("R9 status while pending", d, 32'h1);
    waitIdle(c);
    chk("R4 pending cycles", c, 3);
  endtask

  task automatic t_write_lookup;
    logic [2:0] p; logic v;
    writeEntry(6'd10, 3'd5);
    lookup(6'd10, p, v);
    chk("R2 entry10", {29'd0, p}, 5);
    chk("R5 result valid", {31'd0, v}, 1);
    @(negedge clk);
    chk("R5 valid drops", {31'd0, lkPrioValid}, 0);
    lookup(6'd11, p, v); chk("R2 neighbour untouched", {29'd0, p}, 0);
    lookup(6'd20, p, v); chk("R2 entry20", {29'd0, p}, 3);
  endtask

  task automatic t_read;
    int c; logic [31:0] d;
    writeEntry(6'd63, 3'd7);
    regWrite(2'd0, 32'h0000_00BF);
    regRead(2'd0, d); chk("R8 cmd readback read", d, 32'hBF);
    waitIdle(c);
    regRead(2'd2, d); chk("R3 read entry63", d, 7);
    regWrite(2'd0, 32'h0000_008A); waitIdle(c);
    regRead(2'd2, d); chk("R3 read entry10", d, 5);
    regWrite(2'd0, 32'h0000_0080); waitIdle(c);
    regRead(2'd2, d); chk("R3 read entry0", d, 0);
  endtask

  task automatic t_reserved;
    int c; logic [31:0] d;
    regWrite(2'd1, 32'hFFFF_FFFF);
    regRead(2'd1, d); chk("R8 wdata upper zero", d, 7);
    regWrite(2'd0, 32'hFFFF_FF7F);
    regRead(2'd0, d); chk("R8 cmd reserved zero", d, 32'h3F);
    waitIdle(c);
  endtask

  task automatic t_busy_ignore;
    int c; logic [31:0] d; logic [2:0] p; logic v;
    regWrite(2'd1, 32'd2);
    regWrite(2'd0, 32'h0000_0005);
    regWrite(2'd0, 32'h0000_0006);   // ignored
    regRead(2'd0, d); chk("R7 cmd unchanged", d, 32'h05);
    regRead(2'd3, d); chk("R7 still pending", d, 32'h1);
    waitIdle(c); chk("R7 original timing kept", c, 2);
    lookup(6'd6, p, v); chk("R7 ignored write absent", {29'd0, p}, 0);
    lookup(6'd5, p, v); chk("R7 first write done", {29'd0, p}, 2);
  endtask

  task automatic t_stall;
    logic [31:0] d;
    regWrite(2'd0, 32'h0000_0085);
    lkValid = 1'b1; lkCode = 6'd5;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      regRead(2'd3, d); chk("R6 pending held by lookups", d, 32'h1);
      chk("R5 lookup during access", {29'd0, lkPrio}, 2);
    end
    lkValid = 1'b0;
    @(negedge clk);
    regRead(2'd3, d); chk("R6 finishes after port frees", d, 0);
    regRead(2'd2, d); chk("R3 read after stall", d, 2);
  endtask

  initial begin
    rstN = 1'b0; regWe = 1'b0; regAddr = '0; regWdata = '0;
    lkValid = 1'b0; lkCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_write_lookup();
    t_read();
    t_reserved();
    t_busy_ignore();
    t_stall();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule